// File: doc/BRIEF.md
# Trap Return Sequencer

This block carries out the two privileged return instructions of a core that has machine, supervisor and user modes. When the pipeline presents a return request, the block first checks whether the current privilege allows that kind of return. It then checks whether the saved exception PC it would jump to is aligned. If both checks pass, it produces the new values of the interrupt-enable, previous-enable and previous-privilege status fields, gives the jump target, and on the next clock edge moves the privilege register to the privilege that was saved at trap entry.

The privilege register lives inside the block. The status fields and the two saved exception PCs belong to the surrounding control-register file. They enter as inputs and leave as a write strobe with replacement values. The legality result, the write strobe and the target are combinational and answer in the same cycle as the request. The privilege change takes effect at the clock edge that ends that cycle. A failed check returns an exception code in place of a completion, and the block leaves every field it owns unchanged.

Top module: `trap_return_unit`

## Requirements
- R1: After reset the privilege output is machine (encoding 2'b11). The privilege encodings are user 2'b00, supervisor 2'b01 and machine 2'b11.
- R2: A machine return (`ret_is_sret`=0) while the privilege is not machine raises an exception with code 2 (illegal instruction). It gives no done pulse and no status write.
- R3: A supervisor return (`ret_is_sret`=1) is illegal (code 2) from user privilege. It is legal from supervisor and from machine privilege.
- R4: With `ext_c_en`=0, a legal return whose target PC has either bit 1 or bit 0 set raises an exception with code 0 (misaligned target). An illegal-instruction condition takes precedence over this check.
- R5: With `ext_c_en`=1, the low two bits of the target PC are not checked, and the return completes.
- R6: A completed machine return writes mie := old mpie, mpie := 0 and mpp := 2'b00. It passes sie, spie and spp through unchanged.
- R7: A completed supervisor return writes sie := old spie, spie := 0 and spp := 0. It passes mie, mpie and mpp through unchanged.
- R8: One clock after a completed return, the privilege equals the saved one. For a machine return this is mpp. For a supervisor return it is {1'b0, spp}.
- R9: A saved privilege of 2'b10 (reserved) sets the privilege to user.
- R10: On completion, `target_pc_o` equals `mepc_i` for a machine return and `sepc_i` for a supervisor return.
- R11: On an exception, `st_we_o` stays low, the status outputs equal the status inputs, and the privilege is unchanged on the next cycle.
- R12: While `ret_valid` is low, no done, exception or write strobe appears, and the privilege holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ret_valid | input | 1 | Return request, one cycle per instruction |
| ret_is_sret | input | 1 | 0 = machine return, 1 = supervisor return |
| ext_c_en | input | 1 | Compressed instructions enabled; disables the alignment check |
| mepc_i | input | XLEN | Saved machine exception PC |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| st_mie_i | input | 1 | Current machine interrupt enable |
| st_mpie_i | input | 1 | Current machine previous enable |
| st_mpp_i | input | 2 | Current machine previous privilege |
| st_sie_i | input | 1 | Current supervisor interrupt enable |
| st_spie_i | input | 1 | Current supervisor previous enable |
| st_spp_i | input | 1 | Current supervisor previous privilege |
| priv_o | output | 2 | Current privilege |
| ret_done_o | output | 1 | Return completed this cycle |
| ret_exc_o | output | 1 | Return raised an exception this cycle |
| exc_code_o | output | 4 | Exception cause: 2 illegal, 0 misaligned |
| target_pc_o | output | XLEN | Jump target of the return |
| st_we_o | output | 1 | Status fields write strobe |
| st_mie_o | output | 1 | New machine interrupt enable |
| st_mpie_o | output | 1 | New machine previous enable |
| st_mpp_o | output | 2 | New machine previous privilege |
| st_sie_o | output | 1 | New supervisor interrupt enable |
| st_spie_o | output | 1 | New supervisor previous enable |
| st_spp_o | output | 1 | New supervisor previous privilege |

## Verification
The hardest cases to reach are the ones that depend on the privilege register. There is no trap entry, so the only way down is a completed return, and the only way back to machine mode is reset. Reaching a supervisor return from user mode, or a machine return from supervisor mode, therefore takes a chain of earlier successful returns that each load a chosen saved privilege. The stimulus runs short random episodes that each begin with a reset. Inside an episode the saved privilege and the PC low bits are drawn at random, so the block walks down the privilege levels. Directed sequences add the reserved saved privilege and the case where an illegal return also has a misaligned target.

// File: rtl/trp_pkg.sv
package trp_pkg;
   typedef enum logic [1:0] {
      PRIV_U = 2'b00,
      PRIV_S = 2'b01,
      PRIV_H = 2'b10,
      PRIV_M = 2'b11
   } priv_e;

   localparam int EXC_W = 4;
   localparam logic [EXC_W-1:0] EXC_MISALIGN = 4'd0;
   localparam logic [EXC_W-1:0] EXC_ILLEGAL  = 4'd2;

   typedef struct packed {
      logic       mie;
      logic       mpie;
      logic [1:0] mpp;
      logic       sie;
      logic       spie;
      logic       spp;
   } status_t;

   function automatic priv_e fold_priv(input logic [1:0] enc);
      return (enc == PRIV_H) ? PRIV_U : priv_e'(enc);
   endfunction
endpackage

// File: rtl/trp_legal_check.sv
module trp_legal_check
   import trp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic       is_sret,
   input  priv_e      cur_priv,
   output logic       illegal
);
   logic need_m, need_s;

   always_comb begin
      need_m  = !is_sret && (cur_priv != PRIV_M);
      need_s  = is_sret && (cur_priv == PRIV_U);
      illegal = req && (need_m || need_s);
   end

   assert_illegal_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> !illegal);
   assert_sret_from_m_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req && is_sret && cur_priv == PRIV_M) |-> !illegal);
endmodule

// File: rtl/trp_align_check.sv
module trp_align_check #(
   parameter int XLEN        = 32,
   parameter int ALIGN_BITS  = 2,
   parameter bit CHECK_ALIGN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            ext_c_en,
   input  logic [XLEN-1:0] pc,
   output logic            misaligned
);
   initial begin
      if (ALIGN_BITS < 1 || ALIGN_BITS >= XLEN)
         $error("trp_align_check: ALIGN_BITS out of range");
   end

   generate
      if (CHECK_ALIGN) begin : g_check
         always_comb misaligned = req && !ext_c_en && (pc[ALIGN_BITS-1:0] != '0);
      end else begin : g_nocheck
         always_comb misaligned = 1'b0;
      end
   endgenerate

   assert_no_misalign_with_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_c_en |-> !misaligned);
endmodule

// File: rtl/trp_status_update.sv
module trp_status_update
   import trp_pkg::*;
(
   input  logic    is_sret,
   input  logic    commit,
   input  status_t st_in,
   output status_t st_out,
   output priv_e   next_priv
);
   always_comb begin
      st_out    = st_in;
      next_priv = PRIV_U;
      if (is_sret) begin
         next_priv = fold_priv({1'b0, st_in.spp});
      end else begin
         next_priv = fold_priv(st_in.mpp);
      end
      if (commit) begin
         if (is_sret) begin
            st_out.sie  = st_in.spie;
            st_out.spie = 1'b0;
            st_out.spp  = 1'b0;
         end else begin
            st_out.mie  = st_in.mpie;
            st_out.mpie = 1'b0;
            st_out.mpp  = PRIV_U;
         end
      end
   end
endmodule

// File: rtl/trp_priv_reg.sv
module trp_priv_reg
   import trp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  priv_e next_priv,
   output priv_e priv_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    priv_q <= PRIV_M;
      else if (load) priv_q <= next_priv;
   end

   assert_priv_never_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
      priv_q != PRIV_H);
   assert_priv_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(priv_q));
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
   import trp_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int ALIGN_BITS  = 2,
   parameter bit CHECK_ALIGN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ret_valid,
   input  logic            ret_is_sret,
   input  logic            ext_c_en,
   input  logic [XLEN-1:0] mepc_i,
   input  logic [XLEN-1:0] sepc_i,
   input  logic            st_mie_i,
   input  logic            st_mpie_i,
   input  logic [1:0]      st_mpp_i,
   input  logic            st_sie_i,
   input  logic            st_spie_i,
   input  logic            st_spp_i,
   output logic [1:0]      priv_o,
   output logic            ret_done_o,
   output logic            ret_exc_o,
   output logic [3:0]      exc_code_o,
   output logic [XLEN-1:0] target_pc_o,
   output logic            st_we_o,
   output logic            st_mie_o,
   output logic            st_mpie_o,
   output logic [1:0]      st_mpp_o,
   output logic            st_sie_o,
   output logic            st_spie_o,
   output logic            st_spp_o
);
   initial begin
      if (XLEN < 8) $error("trap_return_unit: XLEN too small");
   end

   priv_e           priv_q, next_priv;
   logic            illegal, misaligned, commit;
   logic [XLEN-1:0] tgt;
   status_t         st_in, st_out;

   assign tgt   = ret_is_sret ? sepc_i : mepc_i;
   assign st_in = '{mie: st_mie_i, mpie: st_mpie_i, mpp: st_mpp_i,
                    sie: st_sie_i, spie: st_spie_i, spp: st_spp_i};

   trp_legal_check u_legal (
      .clk(clk), .rst_n(rst_n), .req(ret_valid), .is_sret(ret_is_sret),
      .cur_priv(priv_q), .illegal(illegal)
   );

   trp_align_check #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS), .CHECK_ALIGN(CHECK_ALIGN)) u_align (
      .clk(clk), .rst_n(rst_n), .req(ret_valid), .ext_c_en(ext_c_en),
      .pc(tgt), .misaligned(misaligned)
   );

   assign commit = ret_valid && !illegal && !misaligned;

   trp_status_update u_upd (
      .is_sret(ret_is_sret), .commit(commit), .st_in(st_in),
      .st_out(st_out), .next_priv(next_priv)
   );

   trp_priv_reg u_priv (
      .clk(clk), .rst_n(rst_n), .load(commit), .next_priv(next_priv), .priv_q(priv_q)
   );

   always_comb begin
      ret_done_o  = commit;
      ret_exc_o   = ret_valid && (illegal || misaligned);
      exc_code_o  = illegal ? EXC_ILLEGAL : EXC_MISALIGN;
      target_pc_o = tgt;
      st_we_o     = commit;
   end

   assign priv_o    = priv_q;
   assign st_mie_o  = st_out.mie;
   assign st_mpie_o = st_out.mpie;
   assign st_mpp_o  = st_out.mpp;
   assign st_sie_o  = st_out.sie;
   assign st_spie_o = st_out.spie;
   assign st_spp_o  = st_out.spp;

   assert_done_excl_exc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ret_done_o && ret_exc_o));
   assert_mret_needs_m_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !ret_is_sret && priv_o != 2'b11) |-> (ret_exc_o && !st_we_o));
   assert_exc_keeps_priv_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ret_exc_o |=> $stable(priv_o));
   assert_mret_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_done_o && !ret_is_sret) |-> (st_mie_o == st_mpie_i && !st_mpie_o && st_mpp_o == 2'b00));
   assert_sret_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_done_o && ret_is_sret) |-> (st_sie_o == st_spie_i && !st_spie_o && !st_spp_o));
   assert_aligned_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_done_o && !ext_c_en) |-> (target_pc_o[1:0] == 2'b00));
endmodule

// File: tb/trap_return_unit_test.sv
`timescale 1ns/1ps
module trap_return_unit_test;
   localparam int XLEN = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ret_valid = 0, ret_is_sret = 0, ext_c_en = 0;
   logic [XLEN-1:0] mepc_i = '0, sepc_i = '0;
   logic st_mie_i = 0, st_mpie_i = 0, st_sie_i = 0, st_spie_i = 0, st_spp_i = 0;
   logic [1:0] st_mpp_i = 0;
   logic [1:0] priv_o, st_mpp_o;
   logic ret_done_o, ret_exc_o, st_we_o;
   logic [3:0] exc_code_o;
   logic [XLEN-1:0] target_pc_o;
   logic st_mie_o, st_mpie_o, st_sie_o, st_spie_o, st_spp_o;

   int checks = 0;
   int errors = 0;
   logic [1:0] model_priv;

   always #10 clk = ~clk;

   trap_return_unit #(.XLEN(XLEN)) uut (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_is_sret(ret_is_sret),
      .ext_c_en(ext_c_en), .mepc_i(mepc_i), .sepc_i(sepc_i),
      .st_mie_i(st_mie_i), .st_mpie_i(st_mpie_i), .st_mpp_i(st_mpp_i),
      .st_sie_i(st_sie_i), .st_spie_i(st_spie_i), .st_spp_i(st_spp_i),
      .priv_o(priv_o), .ret_done_o(ret_done_o), .ret_exc_o(ret_exc_o),
      .exc_code_o(exc_code_o), .target_pc_o(target_pc_o), .st_we_o(st_we_o),
      .st_mie_o(st_mie_o), .st_mpie_o(st_mpie_o), .st_mpp_o(st_mpp_o),
      .st_sie_o(st_sie_o), .st_spie_o(st_spie_o), .st_spp_o(st_spp_o)
   );

   initial begin
      #4_000_000;
      errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic exp_illegal(input logic sret, input logic [1:0] p);
      return sret ? (p == 2'b00) : (p != 2'b11);
   endfunction

   function automatic logic [1:0] exp_next(input logic sret, input logic [1:0] mpp, input logic spp);
      logic [1:0] t;
      t = sret ? {1'b0, spp} : mpp;
      return (t == 2'b10) ? 2'b00 : t;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      ret_valid = 0;
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      model_priv = 2'b11;
      #2 chk("R1 reset priv", priv_o, 2'b11);
   endtask

   // Drive one request at a falling edge, check combinational results, then the privilege.
   task automatic do_op(input logic v, input logic sret, input logic c,
                        input logic [XLEN-1:0] mpc, input logic [XLEN-1:0] spc,
                        input logic [6:0] st);
      logic ill, mis, done;
      logic [XLEN-1:0] tgt;
      logic [1:0] np;
      @(negedge clk);
      ret_valid = v; ret_is_sret = sret; ext_c_en = c;
      mepc_i = mpc; sepc_i = spc;
      {st_mie_i, st_mpie_i, st_mpp_i, st_sie_i, st_spie_i, st_spp_i} = st;
      tgt  = sret ? spc : mpc;
      ill  = v && exp_illegal(sret, model_priv);
      mis  = v && !ill && !c && (tgt[1:0] != 2'b00);
      done = v && !ill && !mis;
      np   = done ? exp_next(sret, st_mpp_i, st_spp_i) : model_priv;
      #5;
      if (!v) begin
         chk("R12 idle done", ret_done_o, 0);
         chk("R12 idle exc", ret_exc_o, 0);
         chk("R12 idle we", st_we_o, 0);
      end else begin
         chk(sret ? "R3 exception flag" : "R2 exception flag", ret_exc_o, ill || mis);
         chk("R4 R5 done flag", ret_done_o, done);
         if (ill) chk(sret ? "R3 illegal code" : "R2 illegal code", exc_code_o, 2);
         else if (mis) chk("R4 misaligned code", exc_code_o, 0);
         chk("R11 write strobe", st_we_o, done);
         if (done) begin
            chk("R10 target pc", target_pc_o, tgt);
            if (!sret)
               chk("R6 mret fields",
                   {st_mie_o, st_mpie_o, st_mpp_o, st_sie_o, st_spie_o, st_spp_o},
                   {st_mpie_i, 1'b0, 2'b00, st_sie_i, st_spie_i, st_spp_i});
            else
               chk("R7 sret fields",
                   {st_mie_o, st_mpie_o, st_mpp_o, st_sie_o, st_spie_o, st_spp_o},
                   {st_mie_i, st_mpie_i, st_mpp_i, st_spie_i, 1'b0, 1'b0});
         end else begin
            chk("R11 fields untouched",
                {st_mie_o, st_mpie_o, st_mpp_o, st_sie_o, st_spie_o, st_spp_o}, st);
         end
      end
      @(posedge clk);
      #2;
      chk((done && st_mpp_i == 2'b10 && !sret) ? "R9 reserved maps to user" : "R8 R11 privilege",
          priv_o, np);
      model_priv = np;
      ret_valid = 0;
   endtask

   initial begin
      logic [31:0] seed;
      seed = 32'd12345;
      void'($urandom(seed));
      model_priv = 2'b11;
      @(negedge clk);
      #2 chk("R1 reset priv", priv_o, 2'b11);
      rst_n = 1;

      // Directed: M -> S via mret, mret from S illegal, sret from S to U, sret from U illegal.
      do_reset();
      do_op(0, 0, 0, 32'h100, 32'h200, 7'b0100_000);
      do_op(1, 0, 0, 32'h100, 32'h200, {1'b0, 1'b1, 2'b01, 3'b000});
      do_op(1, 0, 0, 32'h104, 32'h200, 7'b0);
      do_op(1, 1, 0, 32'h100, 32'h202, {4'b0, 1'b0, 1'b1, 1'b0});
      do_op(1, 1, 0, 32'h100, 32'h200, {4'b0, 1'b0, 1'b1, 1'b0});
      do_op(1, 1, 0, 32'h100, 32'h203, 7'b0);
      do_op(1, 0, 0, 32'h101, 32'h200, 7'b0);
      // Directed: reserved saved privilege from M.
      do_reset();
      do_op(1, 0, 0, 32'h300, 32'h0, {1'b1, 1'b1, 2'b10, 3'b111});
      // Directed: misaligned target with and without compressed support.
      do_reset();
      do_op(1, 0, 0, 32'h302, 32'h0, {1'b0, 1'b1, 2'b11, 3'b000});
      do_op(1, 0, 1, 32'h302, 32'h0, {1'b0, 1'b1, 2'b11, 3'b000});
      do_op(1, 1, 0, 32'h0, 32'h401, {4'b0, 3'b111});

      // Random episodes, each starting from reset.
      for (int ep = 0; ep < 60; ep++) begin
         do_reset();
         for (int k = 0; k < 12; k++) begin
            logic [XLEN-1:0] a, b;
            a = $urandom;
            b = $urandom;
            if ($urandom_range(0, 2) != 0) a[1:0] = 2'b00;
            if ($urandom_range(0, 2) != 0) b[1:0] = 2'b00;
            do_op($urandom_range(0, 9) != 0, 1'($urandom), 1'($urandom_range(0, 3) == 0),
                  a, b, 7'($urandom));
         end
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule